// File: doc/BRIEF.md
# Set/Clear Control Register Bank

This block holds three 16-bit control words for a chip's custom-register window: a DMA control word, an interrupt enable word and an interrupt request word. Software never overwrites them directly. Every write carries a polarity flag in its top data bit, and the low fifteen data bits act as a mask.

When the flag is 1, each masked bit is set. When the flag is 0, each masked bit is cleared. Bits outside the mask keep their value. Because of this, several agents can change individual bits without first reading the register back.

The bank also combines the enable and request words into one interrupt-pending line. Bit 14 of the enable word acts as a master switch for that line. Reads go over the same simple word bus and return data one cycle after the read strobe.

Top module: `sc_ctrl_bank`

## Requirements
- R1: After reset (synchronous, active-low `rst_n`), all three register outputs, `bus_rdata` and `irq_pending_o` are zero.
- R2: A write whose data bit 15 is 1 sets every register bit whose data bit in 14:0 is 1. All other bits of that register are unchanged. The new value is visible on the register output in the cycle after the write strobe.
- R3: A write whose data bit 15 is 0 clears every register bit whose data bit in 14:0 is 1. All other bits of that register are unchanged.
- R4: Offset 12'h096 selects the DMA control word, 12'h09A the interrupt enable word and 12'h09C the interrupt request word. Address bit 0 is ignored, so 12'h097, 12'h09B and 12'h09D reach the same registers.
- R5: A write to any other offset, or a write whose mask bits 14:0 are all zero, leaves all three registers unchanged.
- R6: Stored bit 15 of every register is always 0, on the register outputs and on read data.
- R7: `irq_pending_o` is 1 exactly when enable bit 14 is 1 and the AND of enable bits 14:0 with request bits 14:0 is nonzero. It follows the new register values in the cycle after any write to either word.
- R8: A read strobe puts the addressed register value on `bus_rdata` one cycle later. An unmapped offset returns 0. `bus_rdata` holds its value while no read strobe is given.
- R9: When a read and a write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset in the custom-register window |
| bus_wdata | input | 16 | Write data: bit 15 is the polarity, bits 14:0 are the mask |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| dma_ctl_o | output | 16 | DMA control word |
| int_en_o | output | 16 | Interrupt enable word |
| int_req_o | output | 16 | Interrupt request word |
| irq_pending_o | output | 1 | Enabled request pending with the master enable on |

## Verification
The set/clear function is tried with three kinds of pattern:
- Masks that overlap bits already set, which shows the update merges with the old value rather than replacing it.
- A clear mask that covers both set and unset bits, which shows clear and set are not swapped.
- Writes with a zero mask, an odd address and an unmapped offset, which separate bit-0 aliasing from a genuine miss.

The pending line is driven through cases that each isolate one term:
- Enable and request bits matching with the master bit off.
- The master bit on with no matching request.
- Only the master bit matching itself.

A write and a read in the same cycle distinguish pre-write read data from post-write read data.

// File: rtl/sc_ctrl_pkg.sv
// Shared constants for the set/clear control register bank.
// Assumes a 12-bit byte offset within the custom-register window.
package sc_ctrl_pkg;

    localparam int NREG     = 3;
    localparam int OFF_W    = 12;

    typedef enum logic [1:0] {
        REG_DMA  = 2'd0,
        REG_IEN  = 2'd1,
        REG_IREQ = 2'd2
    } reg_id_e;

    // Offset of each register slot (bit 0 is don't-care on decode)
    function automatic logic [OFF_W-1:0] reg_offset(input int idx);
        case (idx)
            0:       return 12'h096;
            1:       return 12'h09A;
            default: return 12'h09C;
        endcase
    endfunction

endpackage

// File: rtl/sc_word_decode.sv
// Word-aligned address decoder: one-hot select for each register slot.
// Assumes offsets in sc_ctrl_pkg are distinct after bit 0 is dropped.
module sc_word_decode
    import sc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);

    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(1);

    // Compare the address with each slot offset, ignoring bit 0
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        localparam logic [ADDR_W-1:0] OFF = ADDR_W'(reg_offset(g));
        assign sel[g] = ((addr & WORD_MASK) == (OFF & WORD_MASK));
    end

endmodule

// File: rtl/sc_setclr_reg.sv
// One register updated by a polarity flag plus a bit mask.
// Assumes the top data bit is the polarity; that stored bit is held at 0.
module sc_setclr_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);

    localparam int MW = DATA_W - 1;

    logic [MW-1:0] val;
    logic [MW-1:0] nxt;

    // Merge the mask into the current value according to the polarity
    always_comb begin
        if (wdata[DATA_W-1]) nxt = val | wdata[MW-1:0];
        else                 nxt = val & ~wdata[MW-1:0];
    end

    // Hold the value; reload it on a write
    always_ff @(posedge clk) begin
        if (!rst_n)  val <= '0;
        else if (wr) val <= nxt;
    end

    assign q = {1'b0, val};

endmodule

// File: rtl/sc_irq_eval.sv
// Interrupt-pending evaluation from the enable and request words.
// Assumes the bit just below the polarity position is the master enable.
module sc_irq_eval #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] en,
    input  logic [DATA_W-1:0] req,
    output logic              pending
);

    localparam int MASTER = DATA_W - 2;

    logic any_hit;

    // Look for any enabled request among the maskable bits
    always_comb any_hit = |(en[MASTER:0] & req[MASTER:0]);

    assign pending = en[MASTER] & any_hit;

endmodule

// File: rtl/sc_ctrl_bank.sv
// Set/clear control register bank: DMA control, interrupt enable and
// interrupt request words behind a simple word bus with registered reads.
// Assumes one bus operation per cycle; a write and a read may coincide.
module sc_ctrl_bank
    import sc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] dma_ctl_o,
    output logic [DATA_W-1:0] int_en_o,
    output logic [DATA_W-1:0] int_req_o,
    output logic              irq_pending_o
);

    logic [NREG-1:0]   sel;
    logic [DATA_W-1:0] regs [NREG];
    logic [DATA_W-1:0] rd_mux;

    sc_word_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        sc_setclr_reg #(.DATA_W(DATA_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (bus_we & sel[g]),
            .wdata (bus_wdata),
            .q     (regs[g])
        );
    end

    // OR together the selected register; unmapped offsets give zero
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NREG; i++)
            if (sel[i]) rd_mux = rd_mux | regs[i];
    end

    // Capture read data one cycle after the strobe, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_mux;
    end

    assign dma_ctl_o = regs[REG_DMA];
    assign int_en_o  = regs[REG_IEN];
    assign int_req_o = regs[REG_IREQ];

    sc_irq_eval #(.DATA_W(DATA_W)) u_irq (
        .en      (int_en_o),
        .req     (int_req_o),
        .pending (irq_pending_o)
    );

endmodule

// File: rtl/sc_ctrl_bank_chk.sv
// Property checker for sc_ctrl_bank, attached with bind below.
module sc_ctrl_bank_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] dma_ctl_o,
    input logic [DATA_W-1:0] int_en_o,
    input logic [DATA_W-1:0] int_req_o,
    input logic              irq_pending_o
);

    localparam int MW = DATA_W - 1;
    localparam logic [ADDR_W-1:0] WM     = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_DMA  = ADDR_W'(12'h096);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(12'h09A);

    logic hit_dma, hit_ien;
    assign hit_dma = (bus_addr & WM) == (A_DMA & WM);
    assign hit_ien = (bus_addr & WM) == (A_IEN & WM);

    // R2
    set_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_dma && bus_wdata[DATA_W-1]) |=>
        dma_ctl_o[MW-1:0] == ($past(dma_ctl_o[MW-1:0]) | $past(bus_wdata[MW-1:0])));

    // R3
    clr_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && hit_ien && !bus_wdata[DATA_W-1]) |=>
        int_en_o[MW-1:0] == ($past(int_en_o[MW-1:0]) & ~$past(bus_wdata[MW-1:0])));

    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(dma_ctl_o) && $stable(int_en_o) && $stable(int_req_o)));

    // R6
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_ctl_o[DATA_W-1] || int_en_o[DATA_W-1] || int_req_o[DATA_W-1]));

    // R7
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en_o[DATA_W-2] |-> !irq_pending_o);

    // R7
    no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req_o == '0) |-> !irq_pending_o);

    // R8
    rd_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && hit_dma) |=> bus_rdata == $past(dma_ctl_o));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

endmodule

bind sc_ctrl_bank sc_ctrl_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_we        (bus_we),
    .bus_re        (bus_re),
    .bus_rdata     (bus_rdata),
    .dma_ctl_o     (dma_ctl_o),
    .int_en_o      (int_en_o),
    .int_req_o     (int_req_o),
    .irq_pending_o (irq_pending_o)
);

// File: tb/sc_ctrl_bank_bench.sv
// Directed bench for sc_ctrl_bank: one task per scenario.
module sc_ctrl_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata, dma_ctl_o, int_en_o, int_req_o;
    logic        irq_pending_o;

    int n_chk = 0;
    int n_bad = 0;

    sc_ctrl_bank u_sc_ctrl_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_we        (bus_we),
        .bus_re        (bus_re),
        .bus_rdata     (bus_rdata),
        .dma_ctl_o     (dma_ctl_o),
        .int_en_o      (int_en_o),
        .int_req_o     (int_req_o),
        .irq_pending_o (irq_pending_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle, driven at a falling edge; outputs are settled at the next falling edge
    task automatic bus_op(input logic we, input logic re, input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 dma", dma_ctl_o, 16'h0);
        check("R1 ien", int_en_o, 16'h0);
        check("R1 ireq", int_req_o, 16'h0);
        check("R1 rdata", bus_rdata, 16'h0);
        check("R1 irq", {15'h0, irq_pending_o}, 16'h0);
    endtask

    task automatic t_set();
        bus_op(1, 0, 12'h096, 16'h8205);
        check("R2 first set", dma_ctl_o, 16'h0205);
        bus_op(1, 0, 12'h096, 16'h8011);
        check("R2 merged set", dma_ctl_o, 16'h0215);
    endtask

    task automatic t_clear();
        bus_op(1, 0, 12'h096, 16'h0201);
        check("R3 clear", dma_ctl_o, 16'h0014);
    endtask

    task automatic t_decode();
        bus_op(1, 0, 12'h097, 16'h8100);
        check("R4 odd dma", dma_ctl_o, 16'h0114);
        bus_op(1, 0, 12'h09B, 16'h8003);
        check("R4 odd ien", int_en_o, 16'h0003);
        bus_op(1, 0, 12'h09D, 16'h8001);
        check("R4 odd ireq", int_req_o, 16'h0001);
        check("R4 dma untouched", dma_ctl_o, 16'h0114);
    endtask

    task automatic t_ignore();
        bus_op(1, 0, 12'h098, 16'hFFFF);
        bus_op(1, 0, 12'h0A0, 16'h7FFF);
        bus_op(1, 0, 12'h096, 16'h8000);
        bus_op(1, 0, 12'h09A, 16'h0000);
        check("R5 dma", dma_ctl_o, 16'h0114);
        check("R5 ien", int_en_o, 16'h0003);
        check("R5 ireq", int_req_o, 16'h0001);
    endtask

    task automatic t_bit15();
        bus_op(1, 0, 12'h09A, 16'hFFFF);
        check("R6 ien out", int_en_o, 16'h7FFF);
        bus_op(0, 1, 12'h09A, 16'h0);
        check("R6 ien read", bus_rdata, 16'h7FFF);
        bus_op(1, 0, 12'h09A, 16'h7FFF);
        check("R6 ien cleared", int_en_o, 16'h0000);
    endtask

    task automatic t_irq();
        // Request bit 0 already set from t_decode
        bus_op(1, 0, 12'h09A, 16'h8001);
        check("R7 no master", {15'h0, irq_pending_o}, 16'h0);
        bus_op(1, 0, 12'h09A, 16'hC000);
        check("R7 master+match", {15'h0, irq_pending_o}, 16'h1);
        bus_op(1, 0, 12'h09C, 16'h0001);
        check("R7 no match", {15'h0, irq_pending_o}, 16'h0);
        bus_op(1, 0, 12'h09C, 16'hC000);
        check("R7 master bit match", {15'h0, irq_pending_o}, 16'h1);
        bus_op(1, 0, 12'h09A, 16'h4000);
        check("R7 master cleared", {15'h0, irq_pending_o}, 16'h0);
        bus_op(1, 0, 12'h09C, 16'h7FFF);
        bus_op(1, 0, 12'h09A, 16'h7FFF);
    endtask

    task automatic t_read();
        bus_op(0, 1, 12'h096, 16'h0);
        check("R8 read dma", bus_rdata, 16'h0114);
        bus_op(0, 1, 12'h0A0, 16'h0);
        check("R8 unmapped", bus_rdata, 16'h0000);
        bus_op(0, 1, 12'h09A, 16'h0);
        check("R8 read ien", bus_rdata, 16'h0000);
        bus_op(1, 0, 12'h09C, 16'h8123);
        check("R8 hold without strobe", bus_rdata, 16'h0000);
        bus_op(0, 1, 12'h09D, 16'h0);
        check("R8 read ireq", bus_rdata, 16'h0123);
    endtask

    task automatic t_same_cycle();
        bus_op(1, 1, 12'h096, 16'h8800);
        check("R9 old value read", bus_rdata, 16'h0114);
        check("R9 write applied", dma_ctl_o, 16'h0914);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set();
        t_clear();
        t_decode();
        t_ignore();
        t_bit15();
        t_irq();
        t_read();
        t_same_cycle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule